// File: doc/BRIEF.md
# Set-Associative Instruction Cache Lookup

This block answers instruction fetches from a four-way cache of 32-byte lines. It is virtually indexed and physically tagged. Each fetch arrives with its virtual address and the physical address that translation has already produced. Virtual bits [12:5] pick one of 256 sets. The stored tags of every way in that set are then compared with physical bits [28:10]. These bits overlap the index range, so a line is only found when both addresses agree with what was stored.

A hit returns a 32-bit word from the line on the cycle after the fetch is accepted. It also marks the way as most recently used. A miss picks a victim way and sends a line request to an external fill engine. When the whole line comes back, the block commits the data, tag, valid bit, U bit and LRU order in one step and returns the requested word. A fetch made while the cache is disabled, or to an uncacheable region, goes through the fill engine with a no-allocate flag and stores nothing. A one-cycle pulse on the invalidate input sweeps all sets. Fetches are stalled until the sweep is done.

Top module: `icache_lookup`

## Requirements
- R1: When `cache_en` is 0 or `cacheable` is 0, a fetch is never a hit. It raises `fill_req_valid` with `fill_nocache`=1, and the response carries the requested word of the returned line. No line state changes: a later cached fetch to a resident line still hits with its old data.
- R2: The set is chosen by `req_vaddr[12:5]` only. Changing bit 5 reaches a different set. Changing bit 13 reaches the same set.
- R3: A way hits only when its valid bit is 1 and its stored tag equals `req_paddr[28:10]`. This includes bits 10–12, which overlap the index. Physical bits below 10 play no part in the compare.
- R4: On a hit, `resp_valid` rises in the cycle after acceptance with `resp_hit`=1 and no fill request. `resp_data` is word `req_vaddr[4:2]` of the line, where word k occupies line bits [32k+31:32k].
- R5: A hit makes its way the most recently used way of the set.
- R6: On a miss, the victim is the lowest-numbered invalid way, if there is one. Otherwise it is the least recently used way. After reset or invalidation, the order from oldest to newest is way 0, 1, 2, 3.
- R7: A cached miss raises `fill_req_valid` with `fill_paddr` equal to `req_paddr` with bits [4:0] cleared, `fill_way` equal to the victim and `fill_nocache`=0. When `fill_rsp_valid` arrives, the line is committed and the word is returned with `resp_hit`=0.
- R8: The U bit of a line is taken from `req_user` when the line is filled. A later hit reports it on `resp_user`.
- R9: A pulse on `inv_all` clears every valid bit in 256 cycles. `req_ready` is low in the cycle of the pulse and throughout the sweep.
- R10: Only one fetch is outstanding at a time. `req_ready` is low from acceptance until the response is taken. `resp_valid`/`resp_data` hold until `resp_ready`. A fill request holds until `fill_req_ready`.
- R11: After reset, `req_ready`=1, `resp_valid`=0, `fill_req_valid`=0, and every way is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Cache enable |
| cacheable | input | 1 | Fetch targets a cacheable region |
| inv_all | input | 1 | Invalidate-all pulse |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Fetch request accepted |
| req_vaddr | input | 32 | Virtual fetch address |
| req_paddr | input | 29 | Translated physical address |
| req_user | input | 1 | U bit recorded with a filled line |
| resp_valid | output | 1 | Instruction word valid |
| resp_ready | input | 1 | Response consumer ready |
| resp_data | output | 32 | Instruction word |
| resp_user | output | 1 | U bit of the line or fetch |
| resp_hit | output | 1 | Response served from the cache |
| fill_req_valid | output | 1 | Line fill request |
| fill_req_ready | input | 1 | Fill engine accepts request |
| fill_paddr | output | 29 | Line-aligned physical address |
| fill_way | output | 2 | Way that receives the line |
| fill_nocache | output | 1 | Fill is not to be allocated |
| fill_rsp_valid | input | 1 | Returned line valid |
| fill_rsp_line | input | 256 | Returned line, word k at bits [32k+31:32k] |

## Verification
An invalidate pulse and a fetch to a resident line can fall in the same cycle. The bench raises `inv_all` and `req_valid` on the same edge. It then judges that `req_ready` is low at once and stays low no longer than the sweep. Once the fetch is admitted, it must miss and refill into way 0. The bench also overlays a fetch on a stalled response: it holds `resp_ready` low and checks that the word stays put and that no second fetch is admitted.

// File: rtl/icache_lookup.sv
module icache_lookup #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 29,
  parameter int SETS   = 256,
  parameter int WAYS   = 4,
  parameter int WORDS  = 8,
  parameter int IDX_LO = 5,
  parameter int TAG_LO = 10,
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = WORDS * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              cacheable,
  input  logic              inv_all,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PA_W-1:0]   req_paddr,
  input  logic              req_user,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [31:0]       resp_data,
  output logic              resp_user,
  output logic              resp_hit,
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [PA_W-1:0]   fill_paddr,
  output logic [WAY_W-1:0]  fill_way,
  output logic              fill_nocache,
  input  logic              fill_rsp_valid,
  input  logic [LINE_W-1:0] fill_rsp_line
);
  localparam int TAG_W = PA_W - TAG_LO;
  localparam int LN_W  = PA_W - IDX_LO;
  localparam int LRU_W = WAYS * (WAYS - 1) / 2;

  typedef enum logic [2:0] {IDLE, FREQ, FWAIT, RESP, INV} st_t;
  st_t st;

  logic [TAG_W-1:0]  tag_q  [WAYS][SETS];
  logic [LINE_W-1:0] data_q [WAYS][SETS];
  logic [SETS-1:0]   u_q    [WAYS];
  logic [SETS-1:0]   vld_q  [WAYS];
  logic [LRU_W-1:0]  lru_q  [SETS];

  logic              inv_pend;
  logic [IDX_W-1:0]  inv_cnt;
  logic [IDX_W-1:0]  r_set;
  logic [OFF_W-1:0]  r_off;
  logic [LN_W-1:0]   r_line;
  logic [WAY_W-1:0]  r_way;
  logic              r_nc, r_user;
  logic [31:0]       resp_data_q;
  logic              resp_user_q, resp_hit_q;

  function automatic int pidx(int i, int j);
    return i * (2 * WAYS - i - 1) / 2 + j - i - 1;
  endfunction

  function automatic logic [LRU_W-1:0] touch(logic [LRU_W-1:0] v, int w);
    logic [LRU_W-1:0] r;
    r = v;
    for (int i = 0; i < WAYS; i++)
      for (int j = i + 1; j < WAYS; j++)
        if (i == w) r[pidx(i, j)] = 1'b1;
        else if (j == w) r[pidx(i, j)] = 1'b0;
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] pick(logic [LRU_W-1:0] v, logic [WAYS-1:0] vl);
    logic [WAY_W-1:0] r;
    logic found, old;
    r = '0;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (!vl[w] && !found) begin
        r = WAY_W'(w);
        found = 1'b1;
      end
    for (int w = 0; w < WAYS; w++) begin
      old = 1'b1;
      for (int o = 0; o < WAYS; o++)
        if (o != w) begin
          if (w < o) old = old & !v[pidx(w, o)];
          else       old = old &  v[pidx(o, w)];
        end
      if (old && !found) begin
        r = WAY_W'(w);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  wire [IDX_W-1:0] l_set    = req_vaddr[IDX_LO +: IDX_W];
  wire [OFF_W-1:0] l_off    = req_vaddr[2 +: OFF_W];
  wire [TAG_W-1:0] l_tag    = req_paddr[TAG_LO +: TAG_W];
  wire             l_cached = cache_en && cacheable;

  logic [WAYS-1:0]  l_vld, l_hitv;
  logic [WAY_W-1:0] l_hw;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign l_vld[g]  = vld_q[g][l_set];
    assign l_hitv[g] = l_vld[g] && (tag_q[g][l_set] == l_tag);
  end

  always_comb begin
    l_hw = '0;
    for (int w = 0; w < WAYS; w++)
      if (l_hitv[w]) l_hw = WAY_W'(w);
  end

  wire l_hit  = l_cached && |l_hitv;
  wire accept = req_valid && req_ready;
  wire wr_en  = (st == FWAIT) && fill_rsp_valid && !r_nc;

  logic unused_bits;
  assign unused_bits = ^{req_vaddr[VA_W-1:IDX_LO+IDX_W], req_vaddr[1:0], req_paddr[IDX_LO-1:0]};

  assign req_ready      = (st == IDLE) && !inv_all && !inv_pend;
  assign resp_valid     = (st == RESP);
  assign resp_data      = resp_data_q;
  assign resp_user      = resp_user_q;
  assign resp_hit       = resp_hit_q;
  assign fill_req_valid = (st == FREQ);
  assign fill_paddr     = {r_line, {IDX_LO{1'b0}}};
  assign fill_way       = r_way;
  assign fill_nocache   = r_nc;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[r_way][r_set]  <= r_line[TAG_LO-IDX_LO +: TAG_W];
      data_q[r_way][r_set] <= fill_rsp_line;
      u_q[r_way][r_set]    <= r_user;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= IDLE;
      inv_pend    <= 1'b0;
      inv_cnt     <= '0;
      r_set       <= '0;
      r_off       <= '0;
      r_line      <= '0;
      r_way       <= '0;
      r_nc        <= 1'b0;
      r_user      <= 1'b0;
      resp_data_q <= '0;
      resp_user_q <= 1'b0;
      resp_hit_q  <= 1'b0;
      for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else begin
      if (inv_all && st != IDLE && st != INV) inv_pend <= 1'b1;
      case (st)
        IDLE: begin
          if (inv_all || inv_pend) begin
            st       <= INV;
            inv_cnt  <= '0;
            inv_pend <= 1'b0;
          end else if (accept) begin
            r_set  <= l_set;
            r_off  <= l_off;
            r_line <= req_paddr[PA_W-1:IDX_LO];
            r_nc   <= !l_cached;
            r_user <= req_user;
            if (l_hit) begin
              resp_data_q  <= data_q[l_hw][l_set][{l_off, 5'b0} +: 32];
              resp_user_q  <= u_q[l_hw][l_set];
              resp_hit_q   <= 1'b1;
              lru_q[l_set] <= touch(lru_q[l_set], int'(l_hw));
              st           <= RESP;
            end else begin
              r_way <= pick(lru_q[l_set], l_vld);
              st    <= FREQ;
            end
          end
        end
        FREQ: if (fill_req_ready) st <= FWAIT;
        FWAIT: if (fill_rsp_valid) begin
          resp_data_q <= fill_rsp_line[{r_off, 5'b0} +: 32];
          resp_user_q <= r_user;
          resp_hit_q  <= 1'b0;
          if (!r_nc) begin
            vld_q[r_way][r_set] <= 1'b1;
            lru_q[r_set]        <= touch(lru_q[r_set], int'(r_way));
          end
          st <= RESP;
        end
        RESP: if (resp_ready) st <= IDLE;
        INV: begin
          for (int w = 0; w < WAYS; w++) vld_q[w][inv_cnt] <= 1'b0;
          lru_q[inv_cnt] <= '0;
          inv_cnt        <= inv_cnt + 1'b1;
          if (inv_cnt == IDX_W'(SETS - 1)) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/icache_lookup_chk.sv
module icache_lookup_chk #(
  parameter int PA_W  = 29,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inv_all,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             resp_ready,
  input logic [31:0]      resp_data,
  input logic             resp_hit,
  input logic             fill_req_valid,
  input logic             fill_req_ready,
  input logic [PA_W-1:0]  fill_paddr,
  input logic [WAY_W-1:0] fill_way
);
  AST_INV_STALLS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |-> !req_ready); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R10

  AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data) && $stable(resp_hit)); // R10

  AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid && !fill_req_ready |=> fill_req_valid && $stable(fill_paddr) && $stable(fill_way)); // R7

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_hit && $past(!resp_valid) |-> $past(req_valid && req_ready)); // R4

  AST_RESP_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && fill_req_valid)); // R10
endmodule

bind icache_lookup icache_lookup_chk #(.PA_W(PA_W), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
  .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_ready(resp_ready),
  .resp_data(resp_data), .resp_hit(resp_hit),
  .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
  .fill_paddr(fill_paddr), .fill_way(fill_way)
);

// File: tb/icache_lookup_test.sv
module icache_lookup_test;
  logic clk = 0, rst_n = 0;
  logic cache_en = 1, cacheable = 1, inv_all = 0;
  logic req_valid = 0, req_user = 0, resp_ready = 1;
  logic [31:0] req_vaddr = '0;
  logic [28:0] req_paddr = '0;
  logic fill_req_ready = 0, fill_rsp_valid = 0;
  logic [255:0] fill_rsp_line = '0;
  logic req_ready, resp_valid, resp_user, resp_hit, fill_req_valid, fill_nocache;
  logic [31:0] resp_data;
  logic [28:0] fill_paddr;
  logic [1:0] fill_way;

  int checks = 0, errors = 0;
  logic o_fill, o_nc, o_hit, o_user;
  logic [1:0] o_way;
  logic [28:0] o_fpa;
  logic [31:0] o_data;

  always #4 clk = ~clk;

  icache_lookup uut (.*);

  function automatic logic [31:0] wexp(logic [28:0] pa, int off, logic [15:0] salt);
    return {salt, pa[17:5], 3'(off)};
  endfunction

  function automatic logic [255:0] mkline(logic [28:0] pa, logic [15:0] salt);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[32*k +: 32] = wexp(pa, k, salt);
    return l;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] va, input logic [28:0] pa, input logic en,
                       input logic cch, input logic usr, input logic [15:0] salt);
    @(negedge clk);
    cache_en = en; cacheable = cch; req_vaddr = va; req_paddr = pa; req_user = usr;
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    o_fill = 0;
    while (!resp_valid) begin
      if (fill_req_valid) begin
        o_fill = 1; o_way = fill_way; o_nc = fill_nocache; o_fpa = fill_paddr;
        fill_req_ready = 1;
        @(negedge clk);
        fill_req_ready = 0;
        fill_rsp_line = mkline(o_fpa, salt);
        fill_rsp_valid = 1;
        @(negedge clk);
        fill_rsp_valid = 0;
      end else @(negedge clk);
    end
    o_data = resp_data; o_hit = resp_hit; o_user = resp_user;
    @(negedge clk);
    cache_en = 1; cacheable = 1;
  endtask

  localparam logic [31:0] VA_A = 32'h0000_1234;
  localparam logic [28:0] PA_A = {19'h00ABC, 10'h234};

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1, "R11 req_ready", 64'(req_ready), 1);
    chk(resp_valid == 0, "R11 resp_valid", 64'(resp_valid), 0);
    chk(fill_req_valid == 0, "R11 fill_req_valid", 64'(fill_req_valid), 0);
  endtask

  task automatic t_miss_then_hit;
    fetch(VA_A, PA_A, 1, 1, 1, 16'hA1A1);
    chk(o_fill == 1 && o_nc == 0, "R7 miss fill", 64'({o_fill, o_nc}), 64'b10);
    chk(o_fpa == (PA_A & ~29'h1F), "R7 fill_paddr", 64'(o_fpa), 64'(PA_A & ~29'h1F));
    chk(o_way == 0, "R6 cold victim", 64'(o_way), 0);
    chk(o_data == wexp(PA_A, 5, 16'hA1A1) && o_hit == 0, "R7 miss word",
        64'(o_data), 64'(wexp(PA_A, 5, 16'hA1A1)));
    fetch(VA_A + 4, PA_A + 4, 1, 1, 0, 16'hFFFF);
    chk(o_fill == 0 && o_hit == 1, "R4 hit no fill", 64'({o_fill, o_hit}), 64'b01);
    chk(o_data == wexp(PA_A, 6, 16'hA1A1), "R4 hit word", 64'(o_data), 64'(wexp(PA_A, 6, 16'hA1A1)));
    chk(o_user == 1, "R8 stored U bit", 64'(o_user), 1);
  endtask

  task automatic t_index_tag;
    fetch(VA_A ^ 32'h2000, PA_A, 1, 1, 0, 16'hFFFF);
    chk(o_hit == 1 && o_fill == 0, "R2 bit13 same set", 64'(o_hit), 1);
    fetch(VA_A ^ 32'h20, PA_A, 1, 1, 0, 16'hC2C2);
    chk(o_fill == 1 && o_way == 0, "R2 bit5 other set", 64'({o_fill, o_way}), 64'b100);
    fetch(VA_A, PA_A ^ 29'h1000, 1, 1, 0, 16'hC3C3);
    chk(o_fill == 1 && o_way == 1, "R3 overlap tag bit misses", 64'({o_fill, o_way}), 64'b101);
    fetch(VA_A, PA_A ^ 29'h1C0, 1, 1, 0, 16'hFFFF);
    chk(o_hit == 1 && o_data == wexp(PA_A, 5, 16'hA1A1), "R3 low bits ignored",
        64'(o_data), 64'(wexp(PA_A, 5, 16'hA1A1)));
  endtask

  task automatic t_bypass;
    fetch(VA_A, PA_A, 0, 1, 0, 16'hB0B0);
    chk(o_fill == 1 && o_nc == 1, "R1 disabled bypass", 64'({o_fill, o_nc}), 64'b11);
    chk(o_data == wexp(PA_A, 5, 16'hB0B0) && o_hit == 0, "R1 bypass word",
        64'(o_data), 64'(wexp(PA_A, 5, 16'hB0B0)));
    fetch(VA_A, PA_A, 1, 0, 0, 16'hB1B1);
    chk(o_fill == 1 && o_nc == 1, "R1 uncacheable bypass", 64'({o_fill, o_nc}), 64'b11);
    fetch(VA_A, PA_A, 1, 1, 0, 16'hFFFF);
    chk(o_hit == 1 && o_data == wexp(PA_A, 5, 16'hA1A1), "R1 line untouched",
        64'(o_data), 64'(wexp(PA_A, 5, 16'hA1A1)));
  endtask

  task automatic t_lru;
    logic [28:0] p [7];
    for (int i = 1; i < 7; i++) p[i] = {19'h100 + 19'(i), 10'h000};
    for (int i = 1; i < 5; i++) begin
      fetch(32'h800, p[i], 1, 1, 0, 16'(16'h5000 + i));
      chk(o_fill == 1 && o_way == 2'(i - 1), "R6 invalid first", 64'(o_way), 64'(i - 1));
    end
    fetch(32'h800, p[1], 1, 1, 0, 16'hFFFF);
    chk(o_hit == 1 && o_data == wexp(p[1], 0, 16'h5001), "R5 hit way0", 64'(o_data), 64'(wexp(p[1], 0, 16'h5001)));
    fetch(32'h800, p[5], 1, 1, 0, 16'h5005);
    chk(o_fill == 1 && o_way == 1, "R5 victim after touch", 64'(o_way), 1);
    fetch(32'h800, p[6], 1, 1, 0, 16'h5006);
    chk(o_way == 2, "R6 next LRU", 64'(o_way), 2);
    fetch(32'h800, p[2], 1, 1, 0, 16'h5012);
    chk(o_fill == 1 && o_way == 3, "R6 evicted line refills", 64'({o_fill, o_way}), 64'b111);
  endtask

  task automatic t_resp_hold;
    logic [31:0] d;
    @(negedge clk);
    resp_ready = 0; req_vaddr = VA_A; req_paddr = PA_A; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    d = resp_data;
    chk(resp_valid == 1 && resp_hit == 1, "R10 response up", 64'(resp_valid), 1);
    @(negedge clk);
    @(negedge clk);
    chk(resp_valid == 1 && resp_data == d && req_ready == 0, "R10 response held",
        64'({resp_valid, req_ready}), 64'b10);
    resp_ready = 1;
    @(negedge clk);
    chk(resp_valid == 0 && req_ready == 1, "R10 released", 64'({resp_valid, req_ready}), 64'b01);
  endtask

  task automatic t_invalidate;
    int cnt;
    @(negedge clk);
    inv_all = 1; req_vaddr = VA_A; req_paddr = PA_A; req_valid = 1;
    #1;
    chk(req_ready == 0, "R9 same-cycle stall", 64'(req_ready), 0);
    @(negedge clk);
    inv_all = 0;
    cnt = 1;
    while (!req_ready && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
    req_valid = 0;
    chk(cnt >= 256 && cnt <= 257, "R9 sweep length", 64'(cnt), 256);
    fetch(VA_A, PA_A, 1, 1, 0, 16'hD0D0);
    chk(o_fill == 1 && o_way == 0, "R9 line gone", 64'({o_fill, o_way}), 64'b100);
    fetch(VA_A, PA_A, 1, 1, 0, 16'hFFFF);
    chk(o_hit == 1 && o_data == wexp(PA_A, 5, 16'hD0D0), "R9 refill hits",
        64'(o_data), 64'(wexp(PA_A, 5, 16'hD0D0)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset;
    t_miss_then_hit;
    t_index_tag;
    t_bypass;
    t_lru;
    t_resp_hold;
    t_invalidate;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule